// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Aligner

This block sits between a 32-bit integer core and a data memory that is one word wide. The core presents a base register value, a signed 16-bit displacement, an access size, a signed/unsigned flag, the load or store strobe, the store source register and the word the memory returns. The block forms the effective address and the word address sent to memory. For stores it produces per-lane byte enables and a write word. For loads it picks the addressed byte, halfword or word out of the read word and sign- or zero-extends it.

A static select input chooses the byte numbering. With big-endian numbering, address offset 0 within a word is the most significant byte lane. With little-endian numbering, it is the least significant lane. Halfword and word accesses must be naturally aligned. An access that breaks this rule does not touch memory, and the block raises a load or store address-error flag together with the matching exception code. The core uses that code to enter its trap handler.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The effective address is the base input plus the 16-bit offset sign-extended to 32 bits. `mem_addr_o` is that address with its two low bits forced to zero.
- R2: `size_i` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A halfword needs effective address bit 0 clear. A word needs bits 1:0 clear. A byte is never misaligned.
- R3: A misaligned store raises `store_err_o` with `err_code_o` = 5. A misaligned load raises `load_err_o` with code 4. When no error is raised, both flags are 0 and the code is 0. If `load_i` and `store_i` are both high, the access is handled as a store only.
- R4: For an aligned store, `byte_en_o` bit n enables lane n, the bits [8n+7:8n] of the word. The byte at offset k uses lane k in little-endian mode and lane 3-k in big-endian mode. A halfword or word enables every lane its bytes occupy. Without a store, or on a misaligned store, `byte_en_o` is 0.
- R5: `wword_o` carries the low byte of `wdata_i` repeated in all four lanes for a byte store, the low halfword repeated twice for a halfword store, and `wdata_i` unchanged for a word store.
- R6: A load takes the byte at offset k from lane k (little-endian) or lane 3-k (big-endian). For multi-byte values, the byte at the lowest address is the most significant in big-endian mode and the least significant in little-endian mode.
- R7: When `unsigned_i` is 0, byte and halfword loads are sign-extended to 32 bits. When it is 1, they are zero-extended.
- R8: `load_data_o` updates at the rising clock edge where `load_i` is high and `store_i` is low. It holds its value at every other edge.
- R9: A misaligned load sets `load_data_o` to 0 at that edge.
- R10: Synchronous active-low reset clears `load_data_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian_i | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | Zero-extend narrow loads |
| load_i | input | 1 | Load strobe |
| store_i | input | 1 | Store strobe |
| wdata_i | input | 32 | Store source register |
| rdata_i | input | 32 | Word returned by memory |
| mem_addr_o | output | 32 | Word-aligned memory address |
| byte_en_o | output | 4 | Per-lane write enables |
| wword_o | output | 32 | Lane-replicated write word |
| load_data_o | output | 32 | Registered, extended load result |
| load_err_o | output | 1 | Misaligned load |
| store_err_o | output | 1 | Misaligned store |
| err_code_o | output | 5 | Exception code (0, 4 or 5) |

## Verification
On every cycle, the assertions check the following:
- The two error flags are never high together.
- Each flag carries its own code.
- No enable leaves the block when there is no store or the store has faulted.
- The number of active enables is 0, 1, 2 or 4.
- A faulting load leaves a zero result.
- The result holds whenever there is no load.

The actual lane selection and extension under each byte order cannot be captured by these properties. They come from the bench sweep over every combination of order, size, offset, sign flag and displacement, with the expected values built byte by byte from the address.

// File: rtl/lsu_align_pkg.sv
// Package: shared size encoding, data geometry and exception codes for the
// load/store lane aligner. Assumes a 32-bit word split into four byte lanes.
package lsu_align_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned LANE_W  = $clog2(LANES);
    localparam int unsigned XCODE_W = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    localparam logic [XCODE_W-1:0] XC_NONE       = 5'd0;
    localparam logic [XCODE_W-1:0] XC_LOAD_ADDR  = 5'd4;
    localparam logic [XCODE_W-1:0] XC_STORE_ADDR = 5'd5;

endpackage

// File: rtl/lsu_addr_gen.sv
// Address generator: adds the sign-extended displacement to the base,
// produces the word address, the alignment verdict and the lowest byte lane
// the access occupies for the selected byte order.
// Assumes: the lane output is meaningful only when the access is aligned.
module lsu_addr_gen
    import lsu_align_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  acc_size_e         size_i,
    input  logic              big_endian_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              misaligned_o,
    output logic [LANE_W-1:0] lane_lo_o
);

    localparam int unsigned EXT_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] eff_addr;
    logic [LANE_W-1:0] byte_off;

    // Effective address: base plus sign-extended displacement.
    always_comb begin
        eff_addr = base_i + {{EXT_W{offs_i[OFFS_W-1]}}, offs_i};
    end

    assign byte_off    = eff_addr[LANE_W-1:0];
    assign word_addr_o = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

    // Alignment verdict and lowest occupied lane per size and byte order.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                misaligned_o = 1'b0;
                lane_lo_o    = big_endian_i ? ~byte_off : byte_off;
            end
            SZ_HALF: begin
                misaligned_o = byte_off[0];
                lane_lo_o    = big_endian_i ? {~byte_off[1], 1'b0}
                                            : {byte_off[1], 1'b0};
            end
            default: begin
                misaligned_o = |byte_off;
                lane_lo_o    = '0;
            end
        endcase
    end

endmodule

// File: rtl/lsu_store_lane.sv
// Store lane unit: replicates the source data across lanes of its size and
// builds the byte enables from the lowest lane and the size.
// Assumes: store_en_i is already gated by the alignment check.
module lsu_store_lane
    import lsu_align_pkg::*;
(
    input  logic              store_en_i,
    input  acc_size_e         size_i,
    input  logic [LANE_W-1:0] lane_lo_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LANES-1:0]  byte_en_o,
    output logic [DATA_W-1:0] wword_o
);

    logic [LANES-1:0] size_mask;

    // Contiguous lane mask for the access size, before positioning.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    end

    // Position the mask at the lowest lane; no enables without a store.
    always_comb begin
        byte_en_o = store_en_i ? (size_mask << lane_lo_i) : '0;
    end

    // Per-lane replication of the source byte, halfword or word.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            unique case (size_i)
                SZ_BYTE: wword_o[8*ln +: 8] = wdata_i[7:0];
                SZ_HALF: wword_o[8*ln +: 8] = wdata_i[8*(ln % 2) +: 8];
                default: wword_o[8*ln +: 8] = wdata_i[8*ln +: 8];
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Load extractor: shifts the read word so the addressed lane lands at bit 0,
// then truncates to the access size and sign- or zero-extends.
// Assumes: lane_lo_i comes from an aligned access.
module lsu_load_extract
    import lsu_align_pkg::*;
(
    input  logic [DATA_W-1:0] rdata_i,
    input  acc_size_e         size_i,
    input  logic [LANE_W-1:0] lane_lo_i,
    input  logic              unsigned_i,
    output logic [DATA_W-1:0] value_o
);

    logic [DATA_W-1:0] shifted;

    // Bring the lowest occupied lane down to bit 0.
    always_comb begin
        shifted = rdata_i >> {lane_lo_i, 3'b000};
    end

    // Truncate to the access size and extend to a full word.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: value_o = {{(DATA_W-8){shifted[7] & ~unsigned_i}},
                                shifted[7:0]};
            SZ_HALF: value_o = {{(DATA_W-16){shifted[15] & ~unsigned_i}},
                                shifted[15:0]};
            default: value_o = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_lane_aligner.sv
// Top: load/store lane aligner between a 32-bit core and a word-wide memory.
// Combines address generation, store lane steering and load extraction,
// raises load/store address errors and registers the load result.
// Assumes: big_endian_i is static during operation; store wins over load.
module lsu_lane_aligner
    import lsu_align_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFFS_W-1:0] offset_i,
    input  logic [1:0]        size_i,
    input  logic              unsigned_i,
    input  logic              load_i,
    input  logic              store_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LANES-1:0]  byte_en_o,
    output logic [DATA_W-1:0] wword_o,
    output logic [DATA_W-1:0] load_data_o,
    output logic              load_err_o,
    output logic              store_err_o,
    output logic [XCODE_W-1:0] err_code_o
);

    acc_size_e         size_e;
    logic              misaligned;
    logic [LANE_W-1:0] lane_lo;
    logic              do_load;
    logic [DATA_W-1:0] extracted;

    assign size_e  = acc_size_e'(size_i);
    assign do_load = load_i & ~store_i;

    lsu_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W)
    ) u_addr (
        .base_i       (base_i),
        .offs_i       (offset_i),
        .size_i       (size_e),
        .big_endian_i (big_endian_i),
        .word_addr_o  (mem_addr_o),
        .misaligned_o (misaligned),
        .lane_lo_o    (lane_lo)
    );

    lsu_store_lane u_store (
        .store_en_i (store_i & ~misaligned),
        .size_i     (size_e),
        .lane_lo_i  (lane_lo),
        .wdata_i    (wdata_i),
        .byte_en_o  (byte_en_o),
        .wword_o    (wword_o)
    );

    lsu_load_extract u_load (
        .rdata_i    (rdata_i),
        .size_i     (size_e),
        .lane_lo_i  (lane_lo),
        .unsigned_i (unsigned_i),
        .value_o    (extracted)
    );

    // Address-error flags and the matching exception code.
    always_comb begin
        store_err_o = store_i & misaligned;
        load_err_o  = do_load & misaligned;
        if (store_err_o)     err_code_o = XC_STORE_ADDR;
        else if (load_err_o) err_code_o = XC_LOAD_ADDR;
        else                 err_code_o = XC_NONE;
    end

    // Load result register: captures on a load, zero on a faulting load.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_data_o <= '0;
        else if (do_load) load_data_o <= misaligned ? '0 : extracted;
    end

endmodule

// File: rtl/lsu_aligner_chk.sv
// Checker: cycle-by-cycle properties of the aligner's error, enable and
// load-result behaviour. Attached to every instance of the top by bind.
module lsu_aligner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  size_i,
    input logic        load_i,
    input logic        store_i,
    input logic [3:0]  byte_en_o,
    input logic [31:0] load_data_o,
    input logic        load_err_o,
    input logic        store_err_o,
    input logic [4:0]  err_code_o
);

    // R3
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_err_o && store_err_o));

    // R3
    store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_err_o |-> err_code_o == 5'd5);

    // R3
    load_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err_o |-> err_code_o == 5'd4);

    // R4
    be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_i || store_err_o) |-> byte_en_o == 4'b0000);

    // R4
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(byte_en_o) == 0) || ($countones(byte_en_o) == 1) ||
        ($countones(byte_en_o) == 2) || ($countones(byte_en_o) == 4));

    // R2
    byte_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |-> !(load_err_o || store_err_o));

    // R9
    zero_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err_o |=> load_data_o == 32'd0);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && !store_i) |=> $stable(load_data_o));

endmodule

bind lsu_lane_aligner lsu_aligner_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .size_i      (size_i),
    .load_i      (load_i),
    .store_i     (store_i),
    .byte_en_o   (byte_en_o),
    .load_data_o (load_data_o),
    .load_err_o  (load_err_o),
    .store_err_o (store_err_o),
    .err_code_o  (err_code_o)
);

// File: tb/tb_lsu_lane_aligner.sv
// Bench: sweeps byte order, size, offset, sign flag, displacement and data
// patterns; expected values are built byte by byte from the address.
module tb_lsu_lane_aligner;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        big_endian_i;
    logic [31:0] base_i;
    logic [15:0] offset_i;
    logic [1:0]  size_i;
    logic        unsigned_i;
    logic        load_i;
    logic        store_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_i;
    logic [31:0] mem_addr_o;
    logic [3:0]  byte_en_o;
    logic [31:0] wword_o;
    logic [31:0] load_data_o;
    logic        load_err_o;
    logic        store_err_o;
    logic [4:0]  err_code_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] last_load;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_aligner dut (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i),
        .base_i(base_i), .offset_i(offset_i), .size_i(size_i),
        .unsigned_i(unsigned_i), .load_i(load_i), .store_i(store_i),
        .wdata_i(wdata_i), .rdata_i(rdata_i), .mem_addr_o(mem_addr_o),
        .byte_en_o(byte_en_o), .wword_o(wword_o), .load_data_o(load_data_o),
        .load_err_o(load_err_o), .store_err_o(store_err_o),
        .err_code_o(err_code_o)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic is_mis(input logic [1:0] sz, input logic [1:0] k);
        return (sz == 2'd1 && k[0]) || (sz >= 2'd2 && k != 2'd0);
    endfunction

    function automatic int lane_of(input logic be, input int a);
        return be ? 3 - a : a;
    endfunction

    function automatic logic [3:0] exp_be(input logic be, input logic [1:0] sz,
                                          input logic [1:0] k);
        logic [3:0] m = '0;
        for (int i = 0; i < nbytes(sz); i++) m[lane_of(be, int'(k) + i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] exp_load(input logic be, input logic [1:0] sz,
                                             input logic [1:0] k, input logic u,
                                             input logic [31:0] rd);
        logic [31:0] v = '0;
        int n = nbytes(sz);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = rd[8*lane_of(be, int'(k) + i) +: 8];
            if (be) v = (v << 8) | {24'd0, b};
            else    v = v | ({24'd0, b} << (8*i));
        end
        if (!u && n == 1 && v[7])  v = v | 32'hFFFF_FF00;
        if (!u && n == 2 && v[15]) v = v | 32'hFFFF_0000;
        return v;
    endfunction

    // One access: drive at the falling edge, check combinational outputs,
    // then check the registered result after the next rising edge.
    task automatic access(input logic ld, input logic st, input logic be,
                          input logic [1:0] sz, input logic [1:0] k,
                          input logic u, input logic [15:0] offs,
                          input logic [31:0] rd, input logic [31:0] wd);
        logic [31:0] target = 32'h1000_0040 + {30'd0, k};
        logic [31:0] sext = {{16{offs[15]}}, offs};
        logic mis = is_mis(sz, k);
        logic [31:0] wexp;
        logic [4:0] cexp;
        @(negedge clk);
        big_endian_i = be; size_i = sz; unsigned_i = u; offset_i = offs;
        base_i = target - sext; rdata_i = rd; wdata_i = wd;
        load_i = ld; store_i = st;
        #1;
        chk(mem_addr_o == (target & 32'hFFFF_FFFC), "R1 mem_addr", mem_addr_o,
            target & 32'hFFFF_FFFC);
        cexp = (st && mis) ? 5'd5 : (ld && mis) ? 5'd4 : 5'd0;
        chk(err_code_o == cexp, "R3 err_code", {27'd0, err_code_o}, {27'd0, cexp});
        chk(store_err_o == (st && mis), "R2 store_err", {31'd0, store_err_o},
            {31'd0, st && mis});
        chk(load_err_o == (ld && !st && mis), "R3 load_err", {31'd0, load_err_o},
            {31'd0, ld && !st && mis});
        chk(byte_en_o == ((st && !mis) ? exp_be(be, sz, k) : 4'd0), "R4 byte_en",
            {28'd0, byte_en_o}, {28'd0, (st && !mis) ? exp_be(be, sz, k) : 4'd0});
        if (st) begin
            wexp = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
            chk(wword_o == wexp, "R5 wword", wword_o, wexp);
        end
        @(posedge clk);
        #1;
        if (ld && !st) last_load = mis ? 32'd0 : exp_load(be, sz, k, u, rd);
        chk(load_data_o == last_load,
            (ld && !st) ? (mis ? "R9 zero on fault" : "R6 R7 load value") : "R8 hold",
            load_data_o, last_load);
        load_i = 1'b0; store_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] offs_set [4];
        logic [31:0] rd_set   [2];
        logic [31:0] wd_set   [2];
        offs_set[0] = 16'h0000; offs_set[1] = 16'h7FFF;
        offs_set[2] = 16'h8000; offs_set[3] = 16'hFFFD;
        rd_set[0] = 32'h8A7B_C4D5; rd_set[1] = 32'h19F2_6E83;
        wd_set[0] = 32'hCAFE_12F7; wd_set[1] = 32'h0BAD_F00D;
        rst_n = 1'b0; big_endian_i = 1'b0; base_i = '0; offset_i = '0;
        size_i = '0; unsigned_i = 1'b0; load_i = 1'b1; store_i = 1'b0;
        wdata_i = '0; rdata_i = 32'hFFFF_FFFF;
        last_load = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears the result even with a load strobe present
        chk(load_data_o == 32'd0, "R10 reset", load_data_o, 32'd0);
        @(negedge clk);
        load_i = 1'b0;
        rst_n = 1'b1;
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 4; sz++)
                for (int k = 0; k < 4; k++)
                    for (int u = 0; u < 2; u++)
                        for (int oi = 0; oi < 4; oi++)
                            for (int p = 0; p < 2; p++) begin
                                access(1'b1, 1'b0, be[0], sz[1:0], k[1:0], u[0],
                                       offs_set[oi], rd_set[p], wd_set[p]);
                                access(1'b0, 1'b1, be[0], sz[1:0], k[1:0], u[0],
                                       offs_set[oi], rd_set[p ^ 1], wd_set[p]);
                            end
        // R3: both strobes high behave as a store; result holds (R8)
        access(1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 16'h0004, 32'h11F0_3344, 32'd0);
        access(1'b1, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0, 16'h0000, 32'h5566_7788, 32'h1234_5678);
        access(1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 1'b1, 16'h0000, 32'h5566_7788, 32'h1234_5678);
        // R8: idle cycle with changed read word keeps the result
        access(1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 16'h0010, 32'hDEAD_BEEF, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule